// File: doc/BRIEF.md
# Table-Driven Sequencer

This block is a finite state machine whose entire behaviour lives in one synchronous lookup table. There is no decoded transition logic. On every clock the current state code and a few condition inputs are joined into one table address. The word read back carries both the next state code and the control outputs for that step. The registered read data is the state register, so the clock rate does not depend on how many states are used or how tangled the transitions are.

Any state can move to any other state under any condition code. The state encoding places no limit on this. The table is filled through a simple one-word-per-clock write port. While that port is active the machine is held at its start state. When the port is released, the machine starts from state 0 and follows whatever the table now holds.

Top module: `table_fsm`

## Requirements
- R1: A high `rst` at a rising edge makes `state` equal 0 and `ctl` equal 0 after that edge. The machine then stays there for as long as `rst` is held.
- R2: A high `load_en` at a rising edge has two effects. It holds the machine at its start state, so after that edge `state` and `ctl` are both 0. It also stores `load_data` at table address `load_addr`.
- R3: A table write takes place whether `rst` is high or low. A word written while `rst` is high is used by the first step after both `rst` and `load_en` are released.
- R4: When `rst` and `load_en` are both low at a rising edge, the machine takes one step. The table address is {state[6:0], cond[2:0]}, with the state in the upper seven bits. After the edge, `state` is bits [15:9] of the word at that address and `ctl` is bits [8:0] of the same word.
- R5: Any state code from 0 to 127 can move to any state code, and to itself. Each of the eight condition codes of a state selects its own word, independently of the others.
- R6: `cond` is sampled only at the rising edge. A change of `cond` between two edges has no effect on `state` or `ctl` until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset to state 0 with outputs cleared |
| cond | input | 3 | Condition code, synchronous to `clk` |
| load_en | input | 1 | Table write strobe; holds the machine at its start state |
| load_addr | input | 10 | Table address for a write |
| load_data | input | 16 | Table word for a write: next state in [15:9], outputs in [8:0] |
| state | output | 7 | Current state code |
| ctl | output | 9 | Outputs of the word read for the previous state and condition |

## Verification
Two things can fall into the same cycle: a table write and the forced return to state 0. They meet when `rst` is held during a write. They also meet when `load_en` is raised into a machine that is already running, which cuts off a step and replaces a word in the same edge. The bench provokes both cases with directed sequences placed between long randomized runs. It judges the result in two ways. First, `state` and `ctl` must read zero right after the edge. Second, the first step after release must return exactly the word just written to address {0, cond}.

// File: rtl/table_fsm_pkg.sv
package table_fsm_pkg;

   localparam int unsigned TFSM_STATE_W = 7;
   localparam int unsigned TFSM_COND_W  = 3;
   localparam int unsigned TFSM_OUT_W   = 9;
   localparam int unsigned TFSM_BANKS   = 2;

   function automatic bit tfsm_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/tfsm_addr.sv
module tfsm_addr #(
   parameter int unsigned STATE_W    = 7,
   parameter int unsigned COND_W     = 3,
   parameter bit          STATE_HIGH = 1'b1,
   localparam int unsigned AW        = STATE_W + COND_W
) (
   input  logic [STATE_W-1:0] state_i,
   input  logic [COND_W-1:0]  cond_i,
   output logic [AW-1:0]      addr_o
);

   generate
      if (STATE_HIGH) begin : g_state_hi
         assign addr_o = {state_i, cond_i};
      end else begin : g_cond_hi
         assign addr_o = {cond_i, state_i};
      end
   endgenerate

endmodule

// File: rtl/tfsm_table_bank.sv
module tfsm_table_bank #(
   parameter int unsigned AW   = 9,
   parameter int unsigned DW   = 16,
   localparam int unsigned DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [DW-1:0] rdata_o
);

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) mem[waddr_i] <= wdata_i;
      rdata_o <= mem[raddr_i];
   end

endmodule

// File: rtl/tfsm_table.sv
module tfsm_table #(
   parameter int unsigned AW    = 10,
   parameter int unsigned DW    = 16,
   parameter int unsigned BANKS = 2,
   localparam int unsigned SEL_B = (BANKS > 1) ? $clog2(BANKS) : 0,
   localparam int unsigned SEL_W = (SEL_B > 0) ? SEL_B : 1,
   localparam int unsigned LOW_W = AW - SEL_B
) (
   input  logic          clk,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [DW-1:0] rdata_o
);

   generate
      if (BANKS == 1) begin : g_single
         tfsm_table_bank #(.AW(AW), .DW(DW)) u_bank (
            .clk     (clk),
            .we_i    (we_i),
            .waddr_i (waddr_i),
            .wdata_i (wdata_i),
            .raddr_i (raddr_i),
            .rdata_o (rdata_o)
         );
      end else begin : g_banked
         logic [SEL_W-1:0] wsel;
         logic [SEL_W-1:0] rsel;
         logic [SEL_W-1:0] rsel_q;
         logic [DW-1:0]    bank_q [BANKS];

         assign wsel = waddr_i[AW-1 -: SEL_W];
         assign rsel = raddr_i[AW-1 -: SEL_W];

         for (genvar b = 0; b < BANKS; b++) begin : g_bank
            tfsm_table_bank #(.AW(LOW_W), .DW(DW)) u_bank (
               .clk     (clk),
               .we_i    (we_i && (wsel == SEL_W'(b))),
               .waddr_i (waddr_i[LOW_W-1:0]),
               .wdata_i (wdata_i),
               .raddr_i (raddr_i[LOW_W-1:0]),
               .rdata_o (bank_q[b])
            );
         end

         always_ff @(posedge clk) rsel_q <= rsel;

         assign rdata_o = bank_q[rsel_q];
      end
   endgenerate

endmodule

// File: rtl/table_fsm.sv
module table_fsm
   import table_fsm_pkg::*;
#(
   parameter int unsigned STATE_W    = TFSM_STATE_W,
   parameter int unsigned COND_W     = TFSM_COND_W,
   parameter int unsigned OUT_W      = TFSM_OUT_W,
   parameter int unsigned BANKS      = TFSM_BANKS,
   parameter bit          STATE_HIGH = 1'b1,
   localparam int unsigned AW        = STATE_W + COND_W,
   localparam int unsigned WW        = STATE_W + OUT_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [COND_W-1:0]  cond,
   input  logic               load_en,
   input  logic [AW-1:0]      load_addr,
   input  logic [WW-1:0]      load_data,
   output logic [STATE_W-1:0] state,
   output logic [OUT_W-1:0]   ctl
);

   initial begin
      assert (STATE_W >= 1 && COND_W >= 1 && OUT_W >= 1)
         else $error("table_fsm: field widths must be nonzero");
      assert (tfsm_is_pow2(BANKS))
         else $error("table_fsm: BANKS must be a power of two");
      assert (BANKS == 1 || $clog2(BANKS) < AW)
         else $error("table_fsm: too many banks for the address width");
      assert (AW <= 14)
         else $error("table_fsm: table too deep");
   end

   logic          clr_q;
   logic [WW-1:0] tbl_word;
   logic [WW-1:0] cur_word;
   logic [AW-1:0] rd_addr;

   // Reset or loading forces the fed-back word to zero after the edge.
   always_ff @(posedge clk) clr_q <= rst | load_en;

   assign cur_word = clr_q ? '0 : tbl_word;
   assign state    = cur_word[WW-1 -: STATE_W];
   assign ctl      = cur_word[OUT_W-1:0];

   tfsm_addr #(
      .STATE_W    (STATE_W),
      .COND_W     (COND_W),
      .STATE_HIGH (STATE_HIGH)
   ) u_addr (
      .state_i (state),
      .cond_i  (cond),
      .addr_o  (rd_addr)
   );

   tfsm_table #(
      .AW    (AW),
      .DW    (WW),
      .BANKS (BANKS)
   ) u_table (
      .clk     (clk),
      .we_i    (load_en),
      .waddr_i (load_addr),
      .wdata_i (load_data),
      .raddr_i (rd_addr),
      .rdata_o (tbl_word)
   );

endmodule

// File: rtl/table_fsm_chk.sv
module table_fsm_chk #(
   parameter int unsigned STATE_W    = 7,
   parameter int unsigned COND_W     = 3,
   parameter int unsigned OUT_W      = 9,
   parameter bit          STATE_HIGH = 1'b1,
   localparam int unsigned AW        = STATE_W + COND_W,
   localparam int unsigned WW        = STATE_W + OUT_W
) (
   input logic               clk,
   input logic               rst,
   input logic [COND_W-1:0]  cond,
   input logic               load_en,
   input logic [AW-1:0]      load_addr,
   input logic [WW-1:0]      load_data,
   input logic [STATE_W-1:0] state,
   input logic [OUT_W-1:0]   ctl
);

   logic          rst_d  = 1'b0;
   logic          wv     = 1'b0;
   logic          wr_rst = 1'b0;
   logic [AW-1:0] wa     = '0;
   logic [WW-1:0] wd     = '0;
   logic [AW-1:0] cur_a;

   assign cur_a = STATE_HIGH ? {state, cond} : {cond, state};

   always @(posedge clk) begin
      rst_d <= rst;
      if (load_en) begin
         wv     <= 1'b1;
         wa     <= load_addr;
         wd     <= load_data;
         wr_rst <= rst;
      end
   end

   always @(negedge clk) begin
      if (rst_d) begin
         // R1
         rst_clear_chk: assert (state == '0 && ctl == '0)
            else $error("reset did not clear state and outputs");
      end
   end

   // R2
   load_hold_chk: assert property (@(posedge clk) disable iff (rst)
      load_en |=> (state == '0 && ctl == '0));

   // R4
   table_step_chk: assert property (@(posedge clk) disable iff (rst)
      (!load_en && wv && cur_a == wa) |=> ({state, ctl} == $past(wd)));

   // R3
   reset_write_chk: assert property (@(posedge clk) disable iff (rst)
      (!load_en && wv && wr_rst && cur_a == wa) |=> ({state, ctl} == $past(wd)));

endmodule

bind table_fsm table_fsm_chk #(
   .STATE_W    (STATE_W),
   .COND_W     (COND_W),
   .OUT_W      (OUT_W),
   .STATE_HIGH (STATE_HIGH)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cond      (cond),
   .load_en   (load_en),
   .load_addr (load_addr),
   .load_data (load_data),
   .state     (state),
   .ctl       (ctl)
);

// File: tb/table_fsm_test.sv
module table_fsm_test;

   localparam int SW = 7;
   localparam int CW = 3;
   localparam int OW = 9;
   localparam int AW = SW + CW;
   localparam int WW = SW + OW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          load_en = 1'b0;
   logic [CW-1:0] cond = '0;
   logic [AW-1:0] load_addr = '0;
   logic [WW-1:0] load_data = '0;
   logic [SW-1:0] state;
   logic [OW-1:0] ctl;

   always #2 clk = ~clk;

   table_fsm uut (
      .clk       (clk),
      .rst       (rst),
      .cond      (cond),
      .load_en   (load_en),
      .load_addr (load_addr),
      .load_data (load_data),
      .state     (state),
      .ctl       (ctl)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [WW-1:0] tbl [1 << AW];
   logic [WW-1:0] ew;

   function automatic logic [WW-1:0] model_next(input logic [WW-1:0] w,
                                                input logic [CW-1:0] c);
      return tbl[{w[WW-1 -: SW], c}];
   endfunction

   task automatic chk(input string tag, input logic [WW-1:0] got,
                      input logic [WW-1:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // Entered and left at a falling edge.
   task automatic put(input logic [AW-1:0] a, input logic [WW-1:0] d);
      load_en   = 1'b1;
      load_addr = a;
      load_data = d;
      tbl[a]    = d;
      @(posedge clk);
      @(negedge clk);
      load_en = 1'b0;
      ew      = '0;
      chk("R2 load holds start state", {state, ctl}, '0);
   endtask

   task automatic step(input logic [CW-1:0] c, input bit glitch);
      cond = c;
      ew   = model_next(ew, c);
      @(posedge clk);
      if (glitch) begin
         #1 cond = ~c;  // R6: change after the sampling edge
      end
      @(negedge clk);
      chk(glitch ? "R6 cond sampled at edge" : "R4 table step", {state, ctl}, ew);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      ew  = '0;
      chk("R1 reset state", {state, ctl}, '0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset state", {state, ctl}, '0);
      rst = 1'b0;

      // R2: fill the whole table
      for (int a = 0; a < (1 << AW); a++) put(AW'(a), WW'($urandom()));

      // R4, R6: random walk
      for (int i = 0; i < 2000; i++) step(CW'($urandom()), 1'($urandom()));

      // R1: reset in the middle of a run
      do_reset();
      for (int i = 0; i < 50; i++) step(CW'($urandom()), 1'b0);
      do_reset();

      // R5: 0 -> 127, self loop on 127, 127 -> 0
      put({7'd0,   3'd5}, {7'd127, 9'h1AB});
      put({7'd127, 3'd5}, {7'd0,   9'h155});
      put({7'd127, 3'd2}, {7'd127, 9'h0F0});
      step(3'd5, 1'b0);
      chk("R5 jump 0 to 127", {state, ctl}, {7'd127, 9'h1AB});
      step(3'd2, 1'b0);
      step(3'd2, 1'b0);
      chk("R5 self loop on 127", {state, ctl}, {7'd127, 9'h0F0});
      step(3'd5, 1'b0);
      chk("R5 jump 127 to 0", {state, ctl}, {7'd0, 9'h155});

      // R5: eight distinct branches from state 64
      put({7'd0, 3'd7}, {7'd64, 9'h1FF});
      for (int c = 0; c < 8; c++) put({7'd64, 3'(c)}, {7'(c * 16 + 1), 9'(c * 3)});
      for (int c = 0; c < 8; c++) begin
         do_reset();
         step(3'd7, 1'b0);
         step(3'(c), 1'b0);
         chk("R5 branch from 64", {state, ctl}, {7'(c * 16 + 1), 9'(c * 3)});
      end

      // R3: write while reset is held
      rst = 1'b1;
      put({7'd0, 3'd1}, {7'd99, 9'h077});
      rst = 1'b0;
      step(3'd1, 1'b0);
      chk("R3 write under reset", {state, ctl}, {7'd99, 9'h077});

      // R2: load dropped into a running machine
      for (int i = 0; i < 20; i++) step(CW'($urandom()), 1'b0);
      put({7'd0, 3'd6}, {7'd42, 9'h0AA});
      step(3'd6, 1'b0);
      chk("R2 load mid-run takes effect", {state, ctl}, {7'd42, 9'h0AA});
      for (int i = 0; i < 200; i++) step(CW'($urandom()), 1'($urandom()));

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule